// File: doc/BRIEF.md
# Multi-View Line Maximum Merger

The block takes feature-map lines from several camera streams that run independently of each other. It combines them into a single stream. Each view delivers bytes with a valid strobe and a start-of-line flag. The block writes each view's line into a private buffer. Once every participating view holds a complete copy of the same line, the block reads the buffers in parallel. Each output byte is the largest unsigned value found at that byte position across the views. The block compares view against view at each position. It does not compare neighbouring positions within a view.

A view that finishes a line early keeps it and pulls its ready low. New data from that view is held back until the merged line has been read out. This keeps every buffer on the same line number. An enable mask selects which views take part. A view that is switched off counts as zero, and its input is drained and dropped. The merged stream carries a valid strobe, a start-of-line flag, the line index and an end-of-frame flag.

Each view port runs a three-state machine:
- VW_HUNT waits for a start-of-line byte and moves to VW_FILL.
- VW_FILL stores bytes. It moves to VW_HELD on the last position, or back to VW_HUNT if the view is disabled.
- VW_HELD leaves for VW_HUNT on release or when the view is disabled.

The merge controller also has three states:
- MG_WAIT moves to MG_EMIT when all enabled views are held.
- MG_EMIT reads one position per cycle and moves to MG_RELEASE after the last one.
- MG_RELEASE frees the buffers, advances the line index and returns to MG_WAIT.

With the default sizes a line is 1296 bytes (27 positions by 48 channels), and a frame has 27 lines.

Top module: `mvmax_merger`

## Requirements
- R1: After reset, out_valid is low, every in_ready is high, and the first merged line carries line index 0.
- R2: Each merged byte equals the unsigned maximum of the bytes at the same position of the same line from all enabled views.
- R3: A disabled view contributes zero, its in_ready stays high, and the bytes it presents do not affect the output.
- R4: A merged line starts only after every enabled view has delivered that line in full. No output byte appears before that.
- R5: A view holding a complete line drives in_ready low until its buffer is released after the read-out, so its next line is stalled.
- R6: Bytes offered to an idle view before a start-of-line byte are discarded.
- R7: A start-of-line byte arriving while a line is being filled restarts that line at position 0.
- R8: A merged line is LINE_LEN contiguous valid bytes, and out_sol is high only on its first byte.
- R9: out_line counts merged lines from 0 and wraps to 0 after LINES-1. out_eof is high only on the last byte of line LINES-1.
- R10: With the enable mask all zero, no merged output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| view_en | input | NUM_VIEWS | Per-view participation mask |
| in_valid | input | NUM_VIEWS | Per-view byte valid |
| in_sol | input | NUM_VIEWS | Per-view start-of-line flag, set on the first byte |
| in_data | input | NUM_VIEWS*DATA_W | Per-view byte, view v at bits v*DATA_W upward |
| in_ready | output | NUM_VIEWS | Per-view acceptance; a byte is taken when valid and ready are both high |
| out_valid | output | 1 | Merged byte valid |
| out_sol | output | 1 | First byte of a merged line |
| out_eof | output | 1 | Last byte of the last line of a frame |
| out_line | output | $clog2(LINES) | Index of the merged line |
| out_data | output | DATA_W | Merged maximum byte |

## Verification
The hardest condition to reach is one view racing a full line ahead of the others while the rest are still idle. In that state it must be held with ready low, and no merged byte may leak out. The stimulus gets there by streaming two lines back to back on one view while the other views start only after a long delay. The bench then samples that view's ready and the output count inside the gap. A second hard case is a view that restarts a half-filled line with a new start-of-line byte. It is reached by sending a short run of maximum-valued bytes before the real line. Any stale byte would then dominate the maximum and show up in the output.

// File: rtl/mvmax_pkg.sv
package mvmax_pkg;

    typedef enum logic [1:0] {
        VW_HUNT = 2'd0,
        VW_FILL = 2'd1,
        VW_HELD = 2'd2
    } view_state_e;

    typedef enum logic [1:0] {
        MG_WAIT    = 2'd0,
        MG_EMIT    = 2'd1,
        MG_RELEASE = 2'd2
    } merge_state_e;

endpackage

// File: rtl/mvmax_line_store.sv
module mvmax_line_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1296,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // registered read: data for rd_addr appears one cycle later
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/mvmax_view_port.sv
module mvmax_view_port
    import mvmax_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int LINE_LEN = 1296,
    parameter int LINES    = 27,
    localparam int AW      = $clog2(LINE_LEN),
    localparam int LW      = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              release_i,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic [LW-1:0]     tag
);

    localparam logic [AW-1:0] LAST_POS  = AW'(LINE_LEN - 1);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    view_state_e      state_q, state_d;
    logic [AW-1:0]    wptr_q;
    logic             accept;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VW_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        in_ready = (state_q != VW_HELD) || !enable;
        accept   = in_valid && in_ready;
        wr_en    = 1'b0;
        wr_addr  = wptr_q;
        unique case (state_q)
            VW_HUNT: begin
                if (enable && accept && in_sol) begin
                    wr_en   = 1'b1;
                    wr_addr = '0;
                    state_d = VW_FILL;
                end
            end
            VW_FILL: begin
                if (!enable) begin
                    state_d = VW_HUNT;
                end else if (accept) begin
                    wr_en = 1'b1;
                    if (in_sol) begin
                        wr_addr = '0;
                    end else if (wptr_q == LAST_POS) begin
                        state_d = VW_HELD;
                    end
                end
            end
            VW_HELD: begin
                if (!enable || release_i) begin
                    state_d = VW_HUNT;
                end
            end
            default: state_d = VW_HUNT;
        endcase
    end

    // write pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == LAST_POS) begin
                wptr_q <= '0;
            end else begin
                wptr_q <= wr_addr + 1'b1;
            end
        end
    end

    // line-number tag, advanced on every merged line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= '0;
        end else if (release_i) begin
            tag <= (tag == LAST_LINE) ? '0 : tag + 1'b1;
        end
    end

    assign full = (state_q == VW_HELD);

    mvmax_line_store #(
        .DATA_W (DATA_W),
        .DEPTH  (LINE_LEN)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (in_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/mvmax_max_tree.sv
module mvmax_max_tree #(
    parameter int NUM_IN = 4,
    parameter int DATA_W = 8,
    localparam int LEAVES = 1 << $clog2(NUM_IN),
    localparam int NODES  = 2 * LEAVES - 1
) (
    input  logic [NUM_IN*DATA_W-1:0] in_vals,
    input  logic [NUM_IN-1:0]        in_mask,
    output logic [DATA_W-1:0]        out_max
);

    logic [DATA_W-1:0] node [NODES];

    // leaves: masked or padding inputs read as zero
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_IN) begin : g_real
            assign node[LEAVES-1+i] = in_mask[i] ? in_vals[i*DATA_W +: DATA_W] : '0;
        end else begin : g_pad
            assign node[LEAVES-1+i] = '0;
        end
    end

    // internal comparators, heap indexed
    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_cmp
        assign node[n] = (node[2*n+1] >= node[2*n+2]) ? node[2*n+1] : node[2*n+2];
    end

    assign out_max = node[0];

endmodule

// File: rtl/mvmax_merge_ctl.sv
module mvmax_merge_ctl
    import mvmax_pkg::*;
#(
    parameter int NUM_VIEWS = 4,
    parameter int DATA_W    = 8,
    parameter int LINE_LEN  = 1296,
    parameter int LINES     = 27,
    localparam int AW       = $clog2(LINE_LEN),
    localparam int LW       = $clog2(LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VIEWS-1:0] view_en,
    input  logic [NUM_VIEWS-1:0] view_full,
    input  logic [DATA_W-1:0]    max_val,
    output logic                 rd_en,
    output logic [AW-1:0]        rd_addr,
    output logic                 release_o,
    output logic [LW-1:0]        line_cnt,
    output logic                 out_valid,
    output logic                 out_sol,
    output logic                 out_eof,
    output logic [LW-1:0]        out_line,
    output logic [DATA_W-1:0]    out_data
);

    localparam logic [AW-1:0] LAST_POS  = AW'(LINE_LEN - 1);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    merge_state_e  state_q, state_d;
    logic          all_ready;
    logic          s1_valid, s1_first, s1_last;
    logic [LW-1:0] s1_line;

    assign all_ready = (|view_en) && (&(view_full | ~view_en));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MG_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        rd_en     = 1'b0;
        release_o = 1'b0;
        unique case (state_q)
            MG_WAIT: begin
                if (all_ready) begin
                    state_d = MG_EMIT;
                end
            end
            MG_EMIT: begin
                rd_en = 1'b1;
                if (rd_addr == LAST_POS) begin
                    state_d = MG_RELEASE;
                end
            end
            MG_RELEASE: begin
                release_o = 1'b1;
                state_d   = MG_WAIT;
            end
            default: state_d = MG_WAIT;
        endcase
    end

    // read address and line counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr  <= '0;
            line_cnt <= '0;
        end else begin
            if (rd_en) begin
                rd_addr <= (rd_addr == LAST_POS) ? '0 : rd_addr + 1'b1;
            end
            if (release_o) begin
                line_cnt <= (line_cnt == LAST_LINE) ? '0 : line_cnt + 1'b1;
            end
        end
    end

    // stage 1: aligns framing with the registered buffer read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_line  <= '0;
        end else begin
            s1_valid <= rd_en;
            s1_first <= rd_en && (rd_addr == '0);
            s1_last  <= rd_en && (rd_addr == LAST_POS);
            s1_line  <= line_cnt;
        end
    end

    // stage 2: registered output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            out_eof   <= 1'b0;
            out_line  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_sol   <= s1_first;
            out_eof   <= s1_last && (s1_line == LAST_LINE);
            out_line  <= s1_line;
            out_data  <= s1_valid ? max_val : '0;
        end
    end

endmodule

// File: rtl/mvmax_merger.sv
module mvmax_merger #(
    parameter int NUM_VIEWS = 4,
    parameter int DATA_W    = 8,
    parameter int LINE_LEN  = 1296,
    parameter int LINES     = 27,
    localparam int AW       = $clog2(LINE_LEN),
    localparam int LW       = $clog2(LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_VIEWS-1:0]        view_en,
    input  logic [NUM_VIEWS-1:0]        in_valid,
    input  logic [NUM_VIEWS-1:0]        in_sol,
    input  logic [NUM_VIEWS*DATA_W-1:0] in_data,
    output logic [NUM_VIEWS-1:0]        in_ready,
    output logic                        out_valid,
    output logic                        out_sol,
    output logic                        out_eof,
    output logic [LW-1:0]               out_line,
    output logic [DATA_W-1:0]           out_data
);

    logic                        rd_en;
    logic [AW-1:0]               rd_addr;
    logic                        buf_release;
    logic [LW-1:0]               merge_line;
    logic [NUM_VIEWS-1:0]        view_full;
    logic [NUM_VIEWS*DATA_W-1:0] rd_bus;
    logic [NUM_VIEWS*LW-1:0]     view_tag;
    logic [DATA_W-1:0]           max_val;

    for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
        mvmax_view_port #(
            .DATA_W   (DATA_W),
            .LINE_LEN (LINE_LEN),
            .LINES    (LINES)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (view_en[v]),
            .in_valid  (in_valid[v]),
            .in_sol    (in_sol[v]),
            .in_data   (in_data[v*DATA_W +: DATA_W]),
            .in_ready  (in_ready[v]),
            .release_i (buf_release),
            .rd_en     (rd_en),
            .rd_addr   (rd_addr),
            .rd_data   (rd_bus[v*DATA_W +: DATA_W]),
            .full      (view_full[v]),
            .tag       (view_tag[v*LW +: LW])
        );
    end

    mvmax_max_tree #(
        .NUM_IN (NUM_VIEWS),
        .DATA_W (DATA_W)
    ) u_tree (
        .in_vals (rd_bus),
        .in_mask (view_en),
        .out_max (max_val)
    );

    mvmax_merge_ctl #(
        .NUM_VIEWS (NUM_VIEWS),
        .DATA_W    (DATA_W),
        .LINE_LEN  (LINE_LEN),
        .LINES     (LINES)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .view_en   (view_en),
        .view_full (view_full),
        .max_val   (max_val),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .release_o (buf_release),
        .line_cnt  (merge_line),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_eof   (out_eof),
        .out_line  (out_line),
        .out_data  (out_data)
    );

endmodule

// File: rtl/mvmax_merger_chk.sv
module mvmax_merger_chk #(
    parameter int NUM_VIEWS = 4,
    parameter int LINE_LEN  = 1296,
    parameter int LINES     = 27,
    localparam int AW       = $clog2(LINE_LEN),
    localparam int LW       = $clog2(LINES)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_VIEWS-1:0]    view_en,
    input logic [NUM_VIEWS-1:0]    in_ready,
    input logic                    out_valid,
    input logic                    out_sol,
    input logic                    out_eof,
    input logic [LW-1:0]           out_line,
    input logic                    rd_en,
    input logic                    buf_release,
    input logic [NUM_VIEWS-1:0]    view_full,
    input logic [NUM_VIEWS*LW-1:0] view_tag,
    input logic [LW-1:0]           merge_line
);

    localparam logic [AW-1:0] LAST_POS  = AW'(LINE_LEN - 1);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    logic [AW-1:0] pos_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cnt <= '0;
        end else if (out_valid) begin
            pos_cnt <= (pos_cnt == LAST_POS) ? '0 : pos_cnt + 1'b1;
        end
    end

    // R8
    sol_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sol == (pos_cnt == '0)));

    // R9
    eof_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (out_valid && pos_cnt == LAST_POS && out_line == LAST_LINE));

    // R4
    all_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (&(view_full | ~view_en)));

    // R10
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (|view_en));

    for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_vchk
        // R3
        dis_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !view_en[v] |-> in_ready[v]);

        // R5
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (view_full[v] && view_en[v] && !buf_release) |=> view_full[v] || !view_en[v]);

        // R9
        tag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |-> (view_tag[v*LW +: LW] == merge_line));
    end

endmodule

bind mvmax_merger mvmax_merger_chk #(
    .NUM_VIEWS (NUM_VIEWS),
    .LINE_LEN  (LINE_LEN),
    .LINES     (LINES)
) u_mvmax_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .view_en     (view_en),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_sol     (out_sol),
    .out_eof     (out_eof),
    .out_line    (out_line),
    .rd_en       (rd_en),
    .buf_release (buf_release),
    .view_full   (view_full),
    .view_tag    (view_tag),
    .merge_line  (merge_line)
);

// File: tb/test_mvmax_merger.sv
module test_mvmax_merger;

    localparam int NV    = 4;
    localparam int DW    = 8;
    localparam int LEN   = 12;
    localparam int NL    = 3;
    localparam int LW    = $clog2(NL);
    localparam int RECN  = 4096;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NV-1:0]     view_en = '1;
    logic [NV-1:0]     in_valid = '0;
    logic [NV-1:0]     in_sol = '0;
    logic [NV*DW-1:0]  in_data = '0;
    logic [NV-1:0]     in_ready;
    logic              out_valid, out_sol, out_eof;
    logic [LW-1:0]     out_line;
    logic [DW-1:0]     out_data;

    int n_checks = 0;
    int n_fails  = 0;

    logic [DW-1:0] rec_data [RECN];
    logic          rec_sol  [RECN];
    logic          rec_eof  [RECN];
    logic [LW-1:0] rec_line [RECN];
    int            rec_n = 0;

    always #10 clk = ~clk;

    mvmax_merger #(
        .NUM_VIEWS (NV),
        .DATA_W    (DW),
        .LINE_LEN  (LEN),
        .LINES     (NL)
    ) i_mvmax_merger (
        .clk       (clk),
        .rst_n     (rst_n),
        .view_en   (view_en),
        .in_valid  (in_valid),
        .in_sol    (in_sol),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_sol   (out_sol),
        .out_eof   (out_eof),
        .out_line  (out_line),
        .out_data  (out_data)
    );

    always @(negedge clk) begin
        if (out_valid && rec_n < RECN) begin
            rec_data[rec_n] = out_data;
            rec_sol[rec_n]  = out_sol;
            rec_eof[rec_n]  = out_eof;
            rec_line[rec_n] = out_line;
            rec_n = rec_n + 1;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(input int v, input int line, input int k, input int pat);
        return 8'((k * (17 + pat * 6)) + v * 71 + line * 29 + pat * 53);
    endfunction

    function automatic logic [7:0] exp_max(input int line, input int k, input logic [NV-1:0] mask,
                                           input int pat);
        logic [7:0] m = 8'd0;
        for (int v = 0; v < NV; v++) begin
            if (mask[v] && pix(v, line, k, pat) > m) m = pix(v, line, k, pat);
        end
        return m;
    endfunction

    task automatic send_bytes(input int v, input int n, input logic [7:0] value,
                              input logic sol_first);
        int i = 0;
        while (i < n) begin
            @(negedge clk);
            in_valid[v] = 1'b1;
            in_sol[v]   = sol_first && (i == 0);
            in_data[v*DW +: DW] = value;
            if (in_ready[v]) i++;
        end
        @(negedge clk);
        in_valid[v] = 1'b0;
        in_sol[v]   = 1'b0;
    endtask

    task automatic send_line(input int v, input int line, input int pat);
        int i = 0;
        while (i < LEN) begin
            @(negedge clk);
            in_valid[v] = 1'b1;
            in_sol[v]   = (i == 0);
            in_data[v*DW +: DW] = pix(v, line, i, pat);
            if (in_ready[v]) i++;
        end
        @(negedge clk);
        in_valid[v] = 1'b0;
        in_sol[v]   = 1'b0;
    endtask

    task automatic check_line(input int base, input int line, input logic [NV-1:0] mask,
                              input int pat, input logic eof_line, input string req);
        for (int k = 0; k < LEN; k++) begin
            check(rec_data[base+k] == exp_max(line, k, mask, pat), req, "data",
                  rec_data[base+k], exp_max(line, k, mask, pat));
        end
        for (int k = 0; k < LEN; k++) begin
            check(rec_sol[base+k] == (k == 0), "R8", "sol", rec_sol[base+k], (k == 0));
            check(rec_eof[base+k] == (eof_line && k == LEN-1), "R9", "eof",
                  rec_eof[base+k], (eof_line && k == LEN-1));
        end
        check(rec_line[base] == LW'(line), "R9", "line index", rec_line[base], line);
    endtask

    task automatic wait_out();
        repeat (LEN + 10) @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(in_ready == '1, "R1", "in_ready", in_ready, 4'hF);
    endtask

    // R2, R1 (first index 0), R8
    task automatic t_all_views();
        int base = rec_n;
        view_en = 4'hF;
        fork
            send_line(0, 0, 1);
            begin repeat (3) @(negedge clk); send_line(1, 0, 1); end
            begin repeat (7) @(negedge clk); send_line(2, 0, 1); end
            begin repeat (1) @(negedge clk); send_line(3, 0, 1); end
        join
        wait_out();
        check(rec_n == base + LEN, "R8", "byte count", rec_n - base, LEN);
        check_line(base, 0, 4'hF, 1, 1'b0, "R2");
    endtask

    // R4, R5, R9 (eof on last line)
    task automatic t_stall();
        int base = rec_n;
        fork
            begin send_line(0, 1, 2); send_line(0, 2, 2); end
            begin
                repeat (LEN + 15) @(negedge clk);
                check(in_ready[0] == 1'b0, "R5", "early view ready", in_ready[0], 0);
                check(rec_n == base, "R4", "output before all views", rec_n - base, 0);
                fork
                    send_line(1, 1, 2);
                    send_line(2, 1, 2);
                    send_line(3, 1, 2);
                join
                fork
                    send_line(1, 2, 2);
                    send_line(2, 2, 2);
                    send_line(3, 2, 2);
                join
            end
        join
        wait_out();
        check(rec_n == base + 2*LEN, "R8", "byte count", rec_n - base, 2*LEN);
        check_line(base, 1, 4'hF, 2, 1'b0, "R4");
        check_line(base + LEN, 2, 4'hF, 2, 1'b1, "R9");
    endtask

    // R3, R9 (wrap to 0)
    task automatic t_mask();
        int base = rec_n;
        view_en = 4'b0101;
        fork
            send_line(0, 0, 3);
            send_line(2, 0, 3);
            send_bytes(1, LEN, 8'hFF, 1'b1);
            send_bytes(3, LEN, 8'hFF, 1'b1);
            begin
                repeat (LEN + 2) @(negedge clk);
                check(in_ready[1] && in_ready[3], "R3", "disabled ready",
                      {in_ready[3], in_ready[1]}, 3);
            end
        join
        wait_out();
        check(rec_n == base + LEN, "R3", "byte count", rec_n - base, LEN);
        check_line(base, 0, 4'b0101, 3, 1'b0, "R3");
    endtask

    // R6
    task automatic t_hunt();
        int base = rec_n;
        view_en = 4'b0111;
        fork
            begin send_bytes(0, 3, 8'hFF, 1'b0); send_line(0, 1, 4); end
            send_line(1, 1, 4);
            send_line(2, 1, 4);
        join
        wait_out();
        check(rec_n == base + LEN, "R6", "byte count", rec_n - base, LEN);
        check_line(base, 1, 4'b0111, 4, 1'b0, "R6");
    endtask

    // R7
    task automatic t_restart();
        int base = rec_n;
        view_en = 4'hF;
        fork
            begin send_bytes(0, 5, 8'hFF, 1'b1); send_line(0, 2, 5); end
            send_line(1, 2, 5);
            send_line(2, 2, 5);
            send_line(3, 2, 5);
        join
        wait_out();
        check(rec_n == base + LEN, "R7", "byte count", rec_n - base, LEN);
        check_line(base, 2, 4'hF, 5, 1'b1, "R7");
    endtask

    // R10
    task automatic t_empty();
        int base = rec_n;
        view_en = 4'h0;
        fork
            send_line(0, 0, 6);
            send_line(1, 0, 6);
            send_line(2, 0, 6);
            send_line(3, 0, 6);
        join
        wait_out();
        check(rec_n == base, "R10", "output with empty mask", rec_n - base, 0);
        check(in_ready == '1, "R10", "ready with empty mask", in_ready, 4'hF);
        view_en = 4'hF;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R4 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_views();
        t_stall();
        t_mask();
        t_hunt();
        t_restart();
        t_empty();
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule